// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with a single transmit line and a single receive line. A one-entry holding register takes bytes for transmission. A one-entry receive buffer presents each completed frame together with its error flags. The frame shape is chosen at run time by control inputs. These set the number of data bits (7, 8 or 9), optional parity with an odd or even sense, one or two stop bits, the bit order for 8-bit data, and a logic inversion that complements data bits on the wire in both directions.

Bit timing comes from a programmable divisor. The divisor produces a sampling tick at sixteen times the bit rate. The receiver qualifies a start bit at mid-bit and samples every later bit near its centre. It reports parity, framing and overrun conditions; reading the buffer clears them all. The control inputs are meant to be changed only while both directions are idle.

Top module: `uart_frame_core`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits, then the parity bit when enabled, then the stop bits, which are high.
- R2: With cfg_two_stop = 0 the transmitter sends one stop bit; with 1 it sends two. The receiver checks only the first stop bit.
- R3: For 8-bit data, cfg_msb_first = 0 puts bit 0 on the line first and 1 puts bit 7 first, in both directions. For 7- or 9-bit data the order is always bit 0 first.
- R4: With cfg_invert = 1 every transmitted data bit is the complement of the written bit. Start, stop and parity levels keep their normal meaning.
- R5: With cfg_invert = 1 the receive buffer holds the complement of the data bits sampled on rxd.
- R6: The parity bit is the XOR of the data bits as they appear on the line, XOR cfg_par_odd (0 = even, 1 = odd).
- R7: cfg_len encodes the data length: 0 gives 7 bits, 1 or 3 gives 8 bits, 2 gives 9 bits. Unused upper bits of rx_data read as zero.
- R8: One bit lasts 16*(cfg_div+1) clock cycles.
- R9: rx_parity_err is set with a frame whose received parity bit does not match the R6 rule while parity is enabled. It is clear for frames with matching parity.
- R10: rx_frame_err is set with a frame whose first stop bit samples low.
- R11: A frame that completes while rx_valid is high and no read occurs in that cycle sets rx_overrun and replaces the buffer contents. A read in the very cycle of completion counts as consumed: the new frame loads with rx_overrun clear.
- R12: rx_read while rx_valid is high clears rx_valid and all three error flags. rx_read while rx_valid is low has no effect.
- R13: tx_write is accepted only while tx_full is low. A write while tx_full is high is ignored and the byte is never sent.
- R14: A low pulse on rxd shorter than half a bit is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Divisor; the sample tick period is cfg_div+1 clocks |
| cfg_len | input | 2 | Data length select (R7) |
| cfg_msb_first | input | 1 | Bit order for 8-bit data |
| cfg_invert | input | 1 | Complement data bits on the line |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two transmitted stop bits when 1 |
| tx_data | input | 9 | Byte to transmit |
| tx_write | input | 1 | Write strobe for the holding register |
| tx_full | output | 1 | Holding register occupied |
| tx_busy | output | 1 | Holding register occupied or frame in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_read | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 9 | Received data |
| rx_valid | output | 1 | Receive buffer holds unread data |
| rx_parity_err | output | 1 | Parity error on the buffered frame |
| rx_frame_err | output | 1 | Framing error on the buffered frame |
| rx_overrun | output | 1 | Buffered frame overwrote an unread one |

## Verification
Frame completion and a buffer read can land on the same clock edge, and the outcome decides whether rx_overrun is raised. With a divisor of zero the receiver's latency is fixed. The bench therefore measures, at the ports, how many cycles pass from the start bit to rx_valid for one frame. It then sends an identical frame into a full buffer and pulses rx_read on exactly that cycle. The coincident read must leave the new byte valid with rx_overrun clear; a later frame with no read must set it.

// File: rtl/uartx_pkg.sv
`timescale 1ns/1ps
package uartx_pkg;

  localparam int DATA_W = 9;
  localparam int FRW    = 13;

  typedef struct packed {
    logic       msb_first;
    logic       invert;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic [1:0] len;
  } frame_cfg_t;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    case (len)
      2'd0:    data_bits = 4'd7;
      2'd2:    data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction

  // Maps between data order and line order; the mapping is its own inverse.
  function automatic logic [DATA_W-1:0] line_map(input logic [DATA_W-1:0] v,
                                                 input logic [1:0] len,
                                                 input logic msb_first,
                                                 input logic invert);
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] r;
    logic [3:0]        n;
    n = data_bits(len);
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(n));
    r = v & m;
    if (msb_first && n == 4'd8) begin
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
    end
    if (invert) r = r ^ m;
    line_map = r;
  endfunction

endpackage

// File: rtl/uartx_baud.sv
`timescale 1ns/1ps
module uartx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/uartx_tx.sv
`timescale 1ns/1ps
module uartx_tx
  import uartx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic              full,
  output logic              busy,
  output logic              txd
);

  localparam int SUB_W = $clog2(OVS);

  logic [DATA_W-1:0] hold_q;
  logic              hold_v;
  logic [FRW-1:0]    sh_q;
  logic [3:0]        left_q;
  logic [SUB_W-1:0]  sub_q;
  logic              act_q;

  logic [FRW-1:0]    frame;
  logic [DATA_W-1:0] ld;
  logic [3:0]        n;
  logic [3:0]        tot;

  // Frame image, bit 0 first on the line
  always_comb begin
    n     = data_bits(cfg.len);
    ld    = line_map(hold_q, cfg.len, cfg.msb_first, cfg.invert);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n)) frame[1+i] = ld[i];
    end
    if (cfg.par_en) frame[1+int'(n)] = (^ld) ^ cfg.par_odd;
    tot = 4'd2 + n + {3'b000, cfg.par_en} + {3'b000, cfg.two_stop};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      act_q  <= 1'b0;
      txd    <= 1'b1;
    end else begin
      if (wr_en && !hold_v) begin
        hold_q <= wr_data;
        hold_v <= 1'b1;
      end
      if (!act_q && hold_v) begin
        act_q  <= 1'b1;
        hold_v <= 1'b0;
        txd    <= frame[0];
        sh_q   <= frame >> 1;
        left_q <= tot - 4'd1;
        sub_q  <= '0;
      end else if (act_q && tick) begin
        if (sub_q == SUB_W'(OVS-1)) begin
          sub_q <= '0;
          if (left_q == 4'd0) begin
            act_q <= 1'b0;
            txd   <= 1'b1;
          end else begin
            txd    <= sh_q[0];
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 4'd1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign full = hold_v;
  assign busy = hold_v | act_q;

endmodule

// File: rtl/uartx_rx.sv
`timescale 1ns/1ps
module uartx_rx
  import uartx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              perr,
  output logic              ferr,
  output logic              ovr
);

  localparam int SUB_W = $clog2(OVS);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_e;

  rx_st_e            st_q;
  logic              s1_q, s2_q, prev_q;
  logic [SUB_W-1:0]  sub_q;
  logic [3:0]        idx_q;
  logic [DATA_W-1:0] raw_q;
  logic              parb_q;
  logic [3:0]        n;
  logic              at_end;
  logic              fin;

  assign n      = data_bits(len);
  assign at_end = (sub_q == SUB_W'(OVS-1));
  assign fin    = tick && (st_q == R_STOP) && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= R_IDLE;
      prev_q <= 1'b1;
      sub_q  <= '0;
      idx_q  <= '0;
      raw_q  <= '0;
      parb_q <= 1'b0;
    end else if (tick) begin
      prev_q <= s2_q;
      case (st_q)
        R_IDLE: begin
          if (prev_q && !s2_q) begin
            st_q  <= R_START;
            sub_q <= '0;
            raw_q <= '0;
          end
        end
        R_START: begin
          if (sub_q == SUB_W'(OVS/2-1)) begin
            sub_q <= '0;
            idx_q <= '0;
            st_q  <= s2_q ? R_IDLE : R_DATA;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        R_DATA: begin
          if (at_end) begin
            sub_q        <= '0;
            raw_q[idx_q] <= s2_q;
            if (idx_q == n - 4'd1) st_q <= par_en ? R_PAR : R_STOP;
            else                   idx_q <= idx_q + 4'd1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        R_PAR: begin
          if (at_end) begin
            sub_q  <= '0;
            parb_q <= s2_q;
            st_q   <= R_STOP;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: begin
          if (at_end) begin
            sub_q <= '0;
            st_q  <= R_IDLE;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
      endcase
    end
  end

  // Receive buffer and status
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (fin) begin
      data  <= line_map(raw_q, len, msb_first, invert);
      valid <= 1'b1;
      perr  <= par_en & ((^raw_q) ^ parb_q ^ par_odd);
      ferr  <= ~s2_q;
      ovr   <= valid & ~rd;
    end else if (rd) begin
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_frame_core.sv
`timescale 1ns/1ps
module uart_frame_core
  import uartx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_write,
  output logic              tx_full,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_read,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_parity_err,
  output logic              rx_frame_err,
  output logic              rx_overrun
);

  logic       tick;
  frame_cfg_t cfg;

  assign cfg = '{msb_first: cfg_msb_first, invert: cfg_invert, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, two_stop: cfg_two_stop, len: cfg_len};

  uartx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk (clk),
    .rst (rst),
    .div (cfg_div),
    .tick(tick)
  );

  uartx_tx #(.OVS(OVS)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cfg    (cfg),
    .wr_data(tx_data),
    .wr_en  (tx_write),
    .full   (tx_full),
    .busy   (tx_busy),
    .txd    (txd)
  );

  uartx_rx #(.OVS(OVS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .len      (cfg_len),
    .msb_first(cfg_msb_first),
    .invert   (cfg_invert),
    .par_en   (cfg_par_en),
    .par_odd  (cfg_par_odd),
    .rxd      (rxd),
    .rd       (rx_read),
    .data     (rx_data),
    .valid    (rx_valid),
    .perr     (rx_parity_err),
    .ferr     (rx_frame_err),
    .ovr      (rx_overrun)
  );

endmodule

// File: rtl/uartx_chk.sv
`timescale 1ns/1ps
module uartx_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic tx_busy,
  input logic tx_full,
  input logic tx_write,
  input logic rx_read,
  input logic rx_valid,
  input logic rx_parity_err,
  input logic rx_frame_err,
  input logic rx_overrun
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  p_start_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> tx_busy);

  p_hold_take_r13: assert property (@(posedge clk) disable iff (rst)
    (tx_write && !tx_full) |=> tx_full);

  p_flags_need_valid_r12: assert property (@(posedge clk) disable iff (rst)
    (rx_parity_err || rx_frame_err || rx_overrun) |-> rx_valid);

  p_read_clears_ovr_r12: assert property (@(posedge clk) disable iff (rst)
    (rx_read && rx_valid) |=> !rx_overrun);

  p_ovr_after_valid_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overrun) |-> $past(rx_valid));

endmodule

bind uart_frame_core uartx_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .txd          (txd),
  .tx_busy      (tx_busy),
  .tx_full      (tx_full),
  .tx_write     (tx_write),
  .rx_read      (rx_read),
  .rx_valid     (rx_valid),
  .rx_parity_err(rx_parity_err),
  .rx_frame_err (rx_frame_err),
  .rx_overrun   (rx_overrun)
);

// File: tb/uart_frame_core_tb.sv
`timescale 1ns/1ps
module uart_frame_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div = 16'd0;
  logic [1:0]  len = 2'd1;
  logic        msb = 1'b0, inv = 1'b0, pen = 1'b0, podd = 1'b0, two = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_write = 1'b0;
  logic        tx_full, tx_busy, txd;
  logic        loop = 1'b1;
  logic        bench_rx = 1'b1;
  logic        rxd;
  logic        auto_rd = 1'b1, auto_pulse = 1'b0, man_rd = 1'b0;
  logic        rx_read;
  logic [8:0]  rx_data;
  logic        rx_valid, rx_pe, rx_fe, rx_ov;

  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [11:0] got_q[$];
  logic [12:0] line_q[$];
  int          fall_t[$];

  always #2.5 clk = ~clk;

  assign rxd     = loop ? txd : bench_rx;
  assign rx_read = auto_pulse | man_rd;

  uart_frame_core u_dut (
    .clk(clk), .rst(rst), .cfg_div(div), .cfg_len(len), .cfg_msb_first(msb),
    .cfg_invert(inv), .cfg_par_en(pen), .cfg_par_odd(podd), .cfg_two_stop(two),
    .tx_data(tx_data), .tx_write(tx_write), .tx_full(tx_full), .tx_busy(tx_busy),
    .txd(txd), .rxd(rxd), .rx_read(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_pe), .rx_frame_err(rx_fe), .rx_overrun(rx_ov)
  );

  function automatic int nb();
    return (len == 2'd0) ? 7 : (len == 2'd2) ? 9 : 8;
  endfunction

  function automatic int bitp();
    return 16 * (int'(div) + 1);
  endfunction

  function automatic int fbits();
    return 2 + nb() + int'(pen) + int'(two);
  endfunction

  function automatic logic [8:0] dmap(input logic [8:0] v);
    logic [8:0] r;
    int n;
    n = nb();
    r = '0;
    for (int i = 0; i < n; i++) r[i] = (msb && n == 8) ? v[7-i] : v[i];
    for (int i = 0; i < n; i++) if (inv) r[i] = ~r[i];
    return r;
  endfunction

  function automatic logic [12:0] mk_frame(input logic [8:0] lbits, input logic parb,
                                           input logic stopb);
    logic [12:0] f;
    int n;
    n = nb();
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[1+i] = lbits[i];
    if (pen) f[1+n] = parb;
    f[1+n+int'(pen)] = stopb;
    return f;
  endfunction

  function automatic logic [12:0] exp_line(input logic [8:0] d);
    logic [8:0] l;
    l = dmap(d);
    return mk_frame(l, (^l) ^ podd, 1'b1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", total - fails, total);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  // Automatic reader of the receive buffer
  always @(negedge clk) begin
    auto_pulse <= 1'b0;
    if (auto_rd && rx_valid && !auto_pulse) begin
      got_q.push_back({rx_pe, rx_fe, rx_ov, rx_data});
      auto_pulse <= 1'b1;
    end
  end

  // Line monitor: decodes txd at mid-bit
  initial begin
    logic prev;
    logic [12:0] cap;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (prev && !txd && !rst) begin
        int p, fb;
        fall_t.push_back(cyc);
        p = bitp();
        fb = fbits();
        cap = '1;
        repeat (p/2) @(negedge clk);
        for (int b = 0; b < fb; b++) begin
          cap[b] = txd;
          if (b < fb - 1) repeat (p) @(negedge clk);
        end
        line_q.push_back(cap);
      end
      prev = txd;
    end
  end

  task automatic wr(input logic [8:0] d);
    @(negedge clk);
    tx_data = d;
    tx_write = 1'b1;
    @(negedge clk);
    tx_write = 1'b0;
  endtask

  task automatic drive_rx(input logic [12:0] f, input int cnt);
    int p;
    p = bitp();
    for (int b = 0; b < cnt; b++) begin
      bench_rx = f[b];
      repeat (p) @(negedge clk);
    end
    bench_rx = 1'b1;
  endtask

  task automatic loop_one(input logic [8:0] d, input string tag);
    int g0, l0, mask;
    logic [12:0] ln, ex;
    logic [11:0] gv;
    logic [8:0] dm;
    g0 = got_q.size();
    l0 = line_q.size();
    wr(d);
    while (got_q.size() == g0 || line_q.size() == l0 || tx_busy) @(negedge clk);
    repeat (8) @(negedge clk);
    mask = (1 << fbits()) - 1;
    ln = line_q.pop_front();
    ex = exp_line(d);
    chk((ln & 13'(mask)) == (ex & 13'(mask)), {tag, " line R1 R4 R6"},
        32'(ln & 13'(mask)), 32'(ex & 13'(mask)));
    gv = got_q.pop_front();
    dm = d & 9'((1 << nb()) - 1);
    chk(gv == {3'b000, dm}, {tag, " loopback R5 R7"}, 32'(gv), 32'(dm));
  endtask

  task automatic set_cfg(input int dv, input logic [1:0] l, input logic m, input logic i,
                         input logic pe, input logic po, input logic t);
    div = 16'(dv); len = l; msb = m; inv = i; pen = pe; podd = po; two = t;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_frame_chk(input logic [8:0] lbits, input logic parb, input logic stopb,
                              input logic [8:0] exp_d, input logic ep, input logic ef,
                              input string tag);
    drive_rx(mk_frame(lbits, parb, stopb), fbits());
    repeat (bitp()) @(negedge clk);
    chk(rx_valid == 1'b1, {tag, " valid"}, 32'(rx_valid), 1);
    chk(rx_data == exp_d, {tag, " data"}, 32'(rx_data), 32'(exp_d));
    chk({rx_pe, rx_fe} == {ep, ef}, {tag, " flags"}, 32'({rx_pe, rx_fe}), 32'({ep, ef}));
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    int n_meas;
    seed_dummy = $urandom(32'h5eed_c0de);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk(txd == 1'b1 && !tx_busy && !tx_full, "reset tx R1", 32'({txd, tx_busy, tx_full}), 32'h4);
    chk({rx_valid, rx_pe, rx_fe, rx_ov} == 4'b0, "reset rx R12",
        32'({rx_valid, rx_pe, rx_fe, rx_ov}), 0);

    // Directed loopback: order and length corner cases
    set_cfg(0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    loop_one(9'h01, "msb8 R3");
    set_cfg(0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    loop_one(9'h41, "len7 forced lsb R3");
    set_cfg(0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    loop_one(9'h1A5, "len9 inv R3 R4");
    set_cfg(0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    loop_one(9'h0F0, "len code3 R7");

    // Random loopback
    for (int k = 0; k < 24; k++) begin
      set_cfg(int'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      loop_one(9'($urandom), "random");
    end

    // Stop-bit count and bit time: back-to-back frames
    begin
      int cases[3][3];
      cases = '{'{1, 1, 0}, '{1, 0, 0}, '{2, 0, 1}};
      for (int c = 0; c < 3; c++) begin
        int gap, expg;
        set_cfg(cases[c][0], 2'd1, 1'b0, 1'b0, 1'(cases[c][2]), 1'b0, 1'(cases[c][1]));
        fall_t.delete();
        wr(9'h55);
        while (tx_full) @(negedge clk);
        wr(9'h33);
        while (tx_busy || fall_t.size() < 2) @(negedge clk);
        repeat (bitp()) @(negedge clk);
        gap = fall_t[1] - fall_t[0];
        expg = fbits() * bitp();
        chk(gap >= expg - 4 && gap <= expg + 4, "frame period R2 R8", 32'(gap), 32'(expg));
        line_q.delete();
        got_q.delete();
      end
    end

    // Holding register: write while full is dropped
    set_cfg(0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    got_q.delete();
    line_q.delete();
    wr(9'h11);
    repeat (3) @(negedge clk);
    chk(!tx_full, "hold moved R13", 32'(tx_full), 0);
    wr(9'h22);
    chk(tx_full, "hold full R13", 32'(tx_full), 1);
    wr(9'h99);
    while (tx_busy) @(negedge clk);
    repeat (64) @(negedge clk);
    chk(got_q.size() == 2, "dropped write count R13", 32'(got_q.size()), 2);
    if (got_q.size() == 2) begin
      chk(got_q[0][8:0] == 9'h11 && got_q[1][8:0] == 9'h22, "dropped write data R13",
          32'({got_q[0][8:0], got_q[1][8:0]}), 32'({9'h11, 9'h22}));
    end
    got_q.delete();
    line_q.delete();

    // Directed receive from the bench
    loop = 1'b0;
    auto_rd = 1'b0;
    set_cfg(0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_frame_chk(9'h03C, 1'b0, 1'b1, 9'h0C3, 1'b0, 1'b0, "rx invert R5");
    set_cfg(0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame_chk(9'h001, 1'b0, 1'b1, 9'h080, 1'b0, 1'b0, "rx msb R3");
    set_cfg(0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame_chk(9'h1AB, 1'b0, 1'b1, 9'h1AB, 1'b0, 1'b0, "rx len9 R7");
    set_cfg(0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_frame_chk(9'h00F, 1'b1, 1'b1, 9'h00F, 1'b1, 1'b0, "bad even parity R9");
    rx_frame_chk(9'h00F, 1'b0, 1'b1, 9'h00F, 1'b0, 1'b0, "good even parity R9");
    set_cfg(0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    rx_frame_chk(9'h007, 1'b0, 1'b1, 9'h007, 1'b0, 1'b0, "good odd parity R6 R9");
    set_cfg(0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rx_frame_chk(9'h05A, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b1, "stop low R10");
    rx_frame_chk(9'h0A5, 1'b0, 1'b1, 9'h0A5, 1'b0, 1'b0, "one stop in two-stop mode R2");

    // Short low pulse
    set_cfg(0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bench_rx = 1'b0;
    repeat (4) @(negedge clk);
    bench_rx = 1'b1;
    repeat (64) @(negedge clk);
    chk(!rx_valid, "glitch rejected R14", 32'(rx_valid), 0);

    // Read coincident with completion
    begin
      int cnt;
      cnt = 0;
      fork
        drive_rx(mk_frame(9'h03C, 1'b0, 1'b1), fbits());
        begin
          do begin
            @(negedge clk);
            cnt++;
          end while (!rx_valid && cnt < 2000);
        end
      join
      n_meas = cnt;
    end
    repeat (32) @(negedge clk);
    chk(rx_valid && rx_data == 9'h03C, "first frame held R11", 32'(rx_data), 32'h3C);
    fork
      drive_rx(mk_frame(9'h0A5, 1'b0, 1'b1), fbits());
      begin
        repeat (n_meas - 1) @(negedge clk);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
      end
    join
    repeat (32) @(negedge clk);
    chk(rx_valid == 1'b1, "coincident read keeps new valid R11", 32'(rx_valid), 1);
    chk(rx_data == 9'h0A5, "coincident read new data R11", 32'(rx_data), 32'hA5);
    chk(rx_ov == 1'b0, "coincident read no overrun R11", 32'(rx_ov), 0);
    drive_rx(mk_frame(9'h05A, 1'b0, 1'b1), fbits());
    repeat (32) @(negedge clk);
    chk(rx_ov == 1'b1 && rx_valid, "unread overrun R11", 32'({rx_ov, rx_valid}), 3);
    chk(rx_data == 9'h05A, "overrun replaces data R11", 32'(rx_data), 32'h5A);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    @(negedge clk);
    chk({rx_valid, rx_pe, rx_fe, rx_ov} == 4'b0, "read clears R12",
        32'({rx_valid, rx_pe, rx_fe, rx_ov}), 0);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    @(negedge clk);
    chk({rx_valid, rx_pe, rx_fe, rx_ov} == 4'b0 && rx_data == 9'h05A, "empty read ignored R12",
        32'({rx_valid, rx_ov, rx_data}), 32'h05A);

    summary();
    $finish;
  end

endmodule